// File: doc/BRIEF.md
# Snooping Video FIFO Loader with Frame-Synchronous Buffer Flip

This block sits beside a processor bus and keeps a pair of scan-line FIFOs topped up without a separate copy loop. Two equal, aligned address windows serve as frame buffers. At any time one of them is the active buffer. Every processor read that lands in the active window has its returned byte copied into both FIFOs through one shared push strobe, so one pass of reads over the buffer serves the even and the odd scan lines. Reads and writes of the other window, and all writes, leave the FIFOs alone. The processor can therefore build the next frame there at full speed.

A single control/status byte at a fixed address steers the block. Software writes the wanted buffer number, and the swap is held pending until the video side reports the end of a frame. Software also sets a video-enable request, which arms the output and takes effect only at a frame boundary. A flush bit empties both FIFOs before a preload. The FIFO half-full flags, which are low when a FIFO is more than half full, are merged into a level interrupt. The video clock domain sends two signals: a frame-end toggle and a starvation level. Each passes through a two-flop synchroniser and an edge detector. A starvation while video is on turns video off, clears the enable request and sets a sticky underrun flag.

Two state machines hold the control. The buffer machine has the states BUF_STEADY and BUF_PENDING. Its transitions are: select-differs (STEADY to PENDING), cancel (PENDING to STEADY when the select equals the active buffer again) and flip (PENDING to STEADY on a frame pulse, toggling the active buffer). The video machine has the states VID_OFF, VID_ARMED and VID_ON. Its transitions are: arm (OFF to ARMED on the enable request), disarm (ARMED to OFF when the request drops), start (ARMED to ON on a frame pulse), starve (ON to OFF on a starvation edge) and stop (ON to OFF when the request drops).

Top module: `vfl_snoop_loader`

## Requirements
- R1: A read (bus_valid=1, bus_we=0) whose address lies in the active window makes fifo_push high for exactly the next cycle, with fifo_wdata equal to the bus_rdata of the read cycle. Window A is 0x4000-0x7FFF (buffer 0) and window B is 0x8000-0xBFFF (buffer 1).
- R2: Reads of the inactive window, reads of any other address, and every write leave fifo_push low in the next cycle.
- R3: Writing the control byte at 0xFF00 stores bit 0 as the wanted buffer. While the wanted buffer differs from the active one, status bit 1 (pending) is set, one cycle after the write. If the wanted value is written back before a frame end, the swap is cancelled and the active buffer does not change.
- R4: A change of vid_frame_tog that is sampled at clock edge k makes the active buffer (status bit 0) flip at edge k+2 when a swap is pending. The active buffer never changes without a frame end.
- R5: irq is registered. It is high one cycle after both half-full flags are high (each FIFO at or below half), and low one cycle after either flag is low.
- R6: A control write with bit 1 set gives a one-cycle fifo_flush pulse in the next cycle. The bit is not stored.
- R7: Control bit 2 requests video. vid_enable rises only at the first synchronised frame end after the armed state is reached, and it falls one cycle after the request is written to 0.
- R8: A rising edge of vid_starve while video is on drops vid_enable two edges after it is sampled. It also clears the request (status bit 5) and sets the sticky underrun flag (status bit 3). A control write with bit 3 set clears the flag.
- R9: csr_rdata always shows the status: bit0 active buffer, bit1 pending, bit2 video on, bit3 underrun, bit4 irq, bit5 enable request, bit6 wanted buffer, upper bits 0.
- R10: After reset, buffer 0 is active, nothing is pending, video is off, and fifo_push, fifo_flush, irq and csr_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| ctrl_wdata | input | 4 | Write data bits used by the control byte |
| bus_rdata | input | DATA_W | Byte returned by memory for a read |
| csr_rdata | output | DATA_W | Status byte |
| fifo_push | output | 1 | Write strobe shared by both FIFOs |
| fifo_wdata | output | DATA_W | Byte written to both FIFOs |
| fifo_flush | output | 1 | Empties both FIFOs |
| fifo0_hf_n | input | 1 | FIFO 0 half-full flag, low when more than half full |
| fifo1_hf_n | input | 1 | FIFO 1 half-full flag, low when more than half full |
| irq | output | 1 | Level interrupt asking for more data |
| vid_frame_tog | input | 1 | Toggles once per frame end (video domain) |
| vid_starve | input | 1 | High while the video side sees an empty FIFO (video domain) |
| vid_enable | output | 1 | Video output allowed |

## Verification
A behavioural model in the bench predicts every output on every clock. The stimulus mixes reads of both windows, writes to them, reads elsewhere, control writes and frame toggles. Directed reads of window A and then window B, around a flip, show whether the snoop follows the active select or a fixed window. Frame toggles placed two and three edges before a check, and a swap withdrawn before the frame end, separate a correct synchroniser delay and cancel path from an early or an unconditional flip. Half-full patterns with one flag low and with both high, a starvation pulse while video is on, and flush and underrun-clear writes test the remaining flags one at a time.

// File: rtl/vfl_pkg.sv
package vfl_pkg;
    typedef enum logic {
        BUF_STEADY,
        BUF_PENDING
    } buf_state_e;

    typedef enum logic [1:0] {
        VID_OFF,
        VID_ARMED,
        VID_ON
    } vid_state_e;

    // Control byte write fields
    localparam int CTRL_W    = 4;
    localparam int CB_SEL    = 0;
    localparam int CB_FLUSH  = 1;
    localparam int CB_EN     = 2;
    localparam int CB_CLR_UR = 3;

    // Status byte fields
    localparam int ST_W    = 7;
    localparam int SB_ACT  = 0;
    localparam int SB_PEND = 1;
    localparam int SB_VON  = 2;
    localparam int SB_UR   = 3;
    localparam int SB_IRQ  = 4;
    localparam int SB_EN   = 5;
    localparam int SB_SEL  = 6;
endpackage

// File: rtl/vfl_cdc_edge.sv
module vfl_cdc_edge #(
    parameter int STAGES = 2,
    parameter bit TOGGLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    generate
        if (TOGGLE) begin : g_any_edge
            assign pulse = chain[STAGES-1] ^ last;
        end else begin : g_rise_edge
            assign pulse = chain[STAGES-1] & ~last;
        end
    endgenerate
endmodule

// File: rtl/vfl_addr_dec.sv
module vfl_addr_dec #(
    parameter int                 ADDR_W     = 16,
    parameter int                 BUF_LOG2   = 14,
    parameter logic [ADDR_W-1:0]  BUF_A_BASE = 'h4000,
    parameter logic [ADDR_W-1:0]  BUF_B_BASE = 'h8000,
    parameter logic [ADDR_W-1:0]  CSR_ADDR   = 'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              active_sel,
    output logic              hit_active,
    output logic              hit_csr
);
    logic [1:0] in_buf;

    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = (g == 0) ? BUF_A_BASE : BUF_B_BASE;
        assign in_buf[g] = (addr[ADDR_W-1:BUF_LOG2] == BASE[ADDR_W-1:BUF_LOG2]);
    end

    assign hit_active = active_sel ? in_buf[1] : in_buf[0];
    assign hit_csr    = (addr == CSR_ADDR);
endmodule

// File: rtl/vfl_ctrl.sv
module vfl_ctrl
    import vfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CTRL_W-1:0] csr_wdata,
    input  logic              frame_pulse,
    input  logic              starve_pulse,
    input  logic              irq_lvl,
    output logic              active_sel,
    output logic              vid_on,
    output logic              flush,
    output logic [ST_W-1:0]   status
);
    buf_state_e buf_st, buf_nx;
    vid_state_e vid_st, vid_nx;
    logic       act_q, act_nx;
    logic       sel_q, en_q, ur_q, flush_q;
    logic       starve_hit;

    assign starve_hit = starve_pulse && (vid_st == VID_ON);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_st <= BUF_STEADY;
            vid_st <= VID_OFF;
            act_q  <= 1'b0;
        end else begin
            buf_st <= buf_nx;
            vid_st <= vid_nx;
            act_q  <= act_nx;
        end
    end

    // Next state
    always_comb begin
        buf_nx = buf_st;
        act_nx = act_q;
        unique case (buf_st)
            BUF_STEADY: begin
                if (sel_q != act_q) buf_nx = BUF_PENDING;          // select-differs
            end
            BUF_PENDING: begin
                if (sel_q == act_q) begin
                    buf_nx = BUF_STEADY;                           // cancel
                end else if (frame_pulse) begin
                    act_nx = ~act_q;                               // flip
                    buf_nx = BUF_STEADY;
                end
            end
        endcase

        vid_nx = vid_st;
        unique case (vid_st)
            VID_OFF:   if (en_q) vid_nx = VID_ARMED;               // arm
            VID_ARMED: begin
                if (!en_q)            vid_nx = VID_OFF;            // disarm
                else if (frame_pulse) vid_nx = VID_ON;             // start
            end
            VID_ON: begin
                if (starve_pulse) vid_nx = VID_OFF;                // starve
                else if (!en_q)   vid_nx = VID_OFF;                // stop
            end
            default:   vid_nx = VID_OFF;
        endcase
    end

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            en_q    <= 1'b0;
            ur_q    <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= csr_wr && csr_wdata[CB_FLUSH];
            if (csr_wr) sel_q <= csr_wdata[CB_SEL];
            if (starve_hit)  en_q <= 1'b0;
            else if (csr_wr) en_q <= csr_wdata[CB_EN];
            if (starve_hit)                          ur_q <= 1'b1;
            else if (csr_wr && csr_wdata[CB_CLR_UR]) ur_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        active_sel      = act_q;
        vid_on          = (vid_st == VID_ON);
        flush           = flush_q;
        status          = '0;
        status[SB_ACT]  = act_q;
        status[SB_PEND] = (buf_st == BUF_PENDING);
        status[SB_VON]  = (vid_st == VID_ON);
        status[SB_UR]   = ur_q;
        status[SB_IRQ]  = irq_lvl;
        status[SB_EN]   = en_q;
        status[SB_SEL]  = sel_q;
    end

    // R4: the active buffer only moves on a frame end
    a_r4_flip_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(act_q));
    // R7: video only turns on at a frame end
    a_r7_start_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_on) |-> $past(frame_pulse));
    // R8: starvation while on turns video off and latches underrun
    a_r8_starve_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (starve_pulse && vid_on) |=> (!vid_on && ur_q && !en_q));
endmodule

// File: rtl/vfl_snoop_loader.sv
module vfl_snoop_loader
    import vfl_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                BUF_LOG2    = 14,
    parameter logic [ADDR_W-1:0] BUF_A_BASE  = 'h4000,
    parameter logic [ADDR_W-1:0] BUF_B_BASE  = 'h8000,
    parameter logic [ADDR_W-1:0] CSR_ADDR    = 'hFF00,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_flush,
    input  logic              fifo0_hf_n,
    input  logic              fifo1_hf_n,
    output logic              irq,
    input  logic              vid_frame_tog,
    input  logic              vid_starve,
    output logic              vid_enable
);
    logic              active_sel, hit_active, hit_csr;
    logic              frame_pulse, starve_pulse;
    logic              push_q, irq_q;
    logic [DATA_W-1:0] data_q;
    logic [ST_W-1:0]   status;
    logic              csr_wr, snoop;

    vfl_addr_dec #(
        .ADDR_W(ADDR_W), .BUF_LOG2(BUF_LOG2),
        .BUF_A_BASE(BUF_A_BASE), .BUF_B_BASE(BUF_B_BASE), .CSR_ADDR(CSR_ADDR)
    ) u_dec (
        .addr(bus_addr), .active_sel(active_sel),
        .hit_active(hit_active), .hit_csr(hit_csr)
    );

    vfl_cdc_edge #(.STAGES(SYNC_STAGES), .TOGGLE(1'b1)) u_frame_sync (
        .clk(clk), .rst_n(rst_n), .async_in(vid_frame_tog), .pulse(frame_pulse)
    );

    vfl_cdc_edge #(.STAGES(SYNC_STAGES), .TOGGLE(1'b0)) u_starve_sync (
        .clk(clk), .rst_n(rst_n), .async_in(vid_starve), .pulse(starve_pulse)
    );

    assign csr_wr = bus_valid && bus_we && hit_csr;
    assign snoop  = bus_valid && !bus_we && hit_active;

    vfl_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(ctrl_wdata),
        .frame_pulse(frame_pulse), .starve_pulse(starve_pulse), .irq_lvl(irq_q),
        .active_sel(active_sel), .vid_on(vid_enable), .flush(fifo_flush),
        .status(status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            push_q <= snoop;
            if (snoop) data_q <= bus_rdata;
            irq_q  <= fifo0_hf_n && fifo1_hf_n;
        end
    end

    assign fifo_push  = push_q;
    assign fifo_wdata = data_q;
    assign irq        = irq_q;
    assign csr_rdata  = DATA_W'(status);

    // R1: a read of the active window is copied out next cycle
    a_r1_snoop_push: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && hit_active) |=> (fifo_push && fifo_wdata == $past(bus_rdata)));
    // R2: writes never reach the FIFOs
    a_r2_write_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we) |=> !fifo_push);
    // R5: interrupt follows the combined half-full flags
    a_r5_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo0_hf_n && fifo1_hf_n) |=> irq);
    a_r5_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo0_hf_n || !fifo1_hf_n) |=> !irq);
endmodule

// File: tb/vfl_snoop_loader_tb.sv
module vfl_snoop_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [3:0]  ctrl_wdata = '0;
    logic [7:0]  bus_rdata = '0;
    logic [7:0]  csr_rdata, fifo_wdata;
    logic        fifo_push, fifo_flush, irq, vid_enable;
    logic        hf0 = 1'b0, hf1 = 1'b0, ftog = 1'b0, starve = 1'b0;

    int n_chk = 0, n_fail = 0;

    always #10ns clk = ~clk;

    vfl_snoop_loader u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .ctrl_wdata(ctrl_wdata), .bus_rdata(bus_rdata),
        .csr_rdata(csr_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_flush(fifo_flush), .fifo0_hf_n(hf0), .fifo1_hf_n(hf1), .irq(irq),
        .vid_frame_tog(ftog), .vid_starve(starve), .vid_enable(vid_enable)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_act, m_sel, m_pend, m_en, m_ur, m_flush, m_push, m_irq;
    int m_vst;          // 0 off, 1 armed, 2 on
    bit [7:0] m_data;
    bit f1, f2, f3, u1, u2, u3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_sel = 0; m_pend = 0; m_en = 0; m_ur = 0; m_flush = 0;
            m_push = 0; m_irq = 0; m_vst = 0; m_data = 0;
            f1 = 0; f2 = 0; f3 = 0; u1 = 0; u2 = 0; u3 = 0;
        end else begin
            bit fp, sp, wr, in_a, in_b, hit, starve_hit;
            bit n_act, n_pend, n_en, n_ur;
            int n_vst;
            fp = f2 ^ f3;
            sp = u2 & ~u3;
            wr   = bus_valid && bus_we && bus_addr == 16'hFF00;
            in_a = bus_addr[15:14] == 2'b01;
            in_b = bus_addr[15:14] == 2'b10;
            hit  = m_act ? in_b : in_a;
            n_act = m_act; n_pend = m_pend;
            if (m_pend) begin
                if (m_sel == m_act) n_pend = 0;
                else if (fp) begin n_act = ~m_act; n_pend = 0; end
            end else if (m_sel != m_act) n_pend = 1;
            starve_hit = sp && m_vst == 2;
            n_vst = m_vst;
            if (m_vst == 0) begin if (m_en) n_vst = 1; end
            else if (m_vst == 1) begin if (!m_en) n_vst = 0; else if (fp) n_vst = 2; end
            else begin if (sp || !m_en) n_vst = 0; end
            n_en = m_en; n_ur = m_ur;
            if (starve_hit) n_en = 0; else if (wr) n_en = ctrl_wdata[2];
            if (starve_hit) n_ur = 1; else if (wr && ctrl_wdata[3]) n_ur = 0;
            m_flush = wr && ctrl_wdata[1];
            if (wr) m_sel = ctrl_wdata[0];
            m_push = bus_valid && !bus_we && hit;
            if (m_push) m_data = bus_rdata;
            m_irq = hf0 && hf1;
            m_act = n_act; m_pend = n_pend; m_vst = n_vst; m_en = n_en; m_ur = n_ur;
            f3 = f2; f2 = f1; f1 = ftog;
            u3 = u2; u2 = u1; u1 = starve;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_st;
            exp_st = {1'b0, m_sel, m_en, m_irq, m_ur, m_vst == 2, m_pend, m_act};
            chk(fifo_push == m_push, "R1/R2 push", fifo_push, m_push);
            if (m_push) chk(fifo_wdata == m_data, "R1 data", fifo_wdata, m_data);
            chk(fifo_flush == m_flush, "R6 flush", fifo_flush, m_flush);
            chk(irq == m_irq, "R5 irq", irq, m_irq);
            chk(vid_enable == (m_vst == 2), "R7 vid_enable", vid_enable, m_vst == 2);
            chk(csr_rdata == exp_st, "R9 status", csr_rdata, exp_st);
        end
    end

    task automatic drive(input bit v, input bit we, input bit [15:0] a,
                         input bit [3:0] wd, input bit [7:0] rd);
        @(negedge clk);
        bus_valid = v; bus_we = we; bus_addr = a; ctrl_wdata = wd; bus_rdata = rd;
    endtask
    task automatic idle();                         drive(0, 0, 16'h0, 4'h0, 8'h0); endtask
    task automatic rd(input bit [15:0] a, input bit [7:0] d); drive(1, 0, a, 4'h0, d); endtask
    task automatic wr_ctrl(input bit [3:0] d);     drive(1, 1, 16'hFF00, d, 8'h0); endtask
    task automatic frame_end();
        @(negedge clk);
        bus_valid = 0; bus_we = 0; ftog = ~ftog;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(fifo_push == 0 && fifo_flush == 0, "R10 push/flush", {fifo_push, fifo_flush}, 0);
        chk(irq == 0 && vid_enable == 0, "R10 irq/video", {irq, vid_enable}, 0);
        chk(csr_rdata == 8'h00, "R10 status", csr_rdata, 0);
        rst_n = 1'b1;
        idle(); idle();

        // R1: read of window A while buffer 0 is active
        rd(16'h4010, 8'hA5); idle();
        chk(fifo_push == 1 && fifo_wdata == 8'hA5, "R1 snoop A", fifo_wdata, 8'hA5);
        // R2: inactive window, write, other address
        rd(16'h8000, 8'h11); idle();
        chk(fifo_push == 0, "R2 inactive read", fifo_push, 0);
        drive(1, 1, 16'h4020, 4'h0, 8'h22); idle();
        chk(fifo_push == 0, "R2 write", fifo_push, 0);
        rd(16'h2000, 8'h33); idle();
        chk(fifo_push == 0, "R2 other", fifo_push, 0);

        // R3: request buffer 1, pending, old buffer still snooped
        wr_ctrl(4'h1); idle(); idle();
        chk(csr_rdata[1:0] == 2'b10, "R3 pending", csr_rdata[1:0], 2'b10);
        rd(16'h7FFF, 8'h5A); idle();
        chk(fifo_push == 1 && fifo_wdata == 8'h5A, "R3 old active", fifo_wdata, 8'h5A);
        // R4: flip two edges after the toggle is sampled
        frame_end(); idle(); idle();
        chk(csr_rdata[0] == 0, "R4 not yet", csr_rdata[0], 0);
        idle();
        chk(csr_rdata[1:0] == 2'b01, "R4 flipped", csr_rdata[1:0], 2'b01);
        rd(16'h8123, 8'hC3); idle();
        chk(fifo_push == 1 && fifo_wdata == 8'hC3, "R3 snoop B", fifo_wdata, 8'hC3);
        rd(16'h4123, 8'h3C); idle();
        chk(fifo_push == 0, "R3 A now inactive", fifo_push, 0);

        // R3: cancelled swap
        wr_ctrl(4'h0); idle(); idle();
        chk(csr_rdata[1] == 1, "R3 pending again", csr_rdata[1], 1);
        wr_ctrl(4'h1); idle(); idle();
        chk(csr_rdata[1] == 0, "R3 cancelled", csr_rdata[1], 0);
        frame_end(); idle(); idle(); idle();
        chk(csr_rdata[0] == 1, "R3 cancel keeps active", csr_rdata[0], 1);

        // R5: interrupt
        @(negedge clk); hf0 = 1; hf1 = 0;
        @(negedge clk);
        chk(irq == 0, "R5 one flag", irq, 0);
        hf1 = 1;
        @(negedge clk);
        chk(irq == 1, "R5 both flags", irq, 1);
        hf0 = 0;
        @(negedge clk);
        chk(irq == 0, "R5 drop", irq, 0);

        // R6: flush pulse
        wr_ctrl(4'h3); idle();
        chk(fifo_flush == 1, "R6 pulse", fifo_flush, 1);
        idle();
        chk(fifo_flush == 0, "R6 single", fifo_flush, 0);

        // R7: enable waits for a frame end
        wr_ctrl(4'h5); idle(); idle(); idle();
        chk(vid_enable == 0, "R7 armed only", vid_enable, 0);
        frame_end(); idle(); idle();
        chk(vid_enable == 0, "R7 not yet", vid_enable, 0);
        idle();
        chk(vid_enable == 1, "R7 on", vid_enable, 1);

        // R8: starvation
        @(negedge clk); starve = 1;
        idle(); idle(); idle();
        chk(vid_enable == 0, "R8 off", vid_enable, 0);
        chk(csr_rdata[5] == 0 && csr_rdata[3] == 1, "R8 flags", csr_rdata, 8'h09);
        starve = 0;
        wr_ctrl(4'h9); idle();
        chk(csr_rdata[3] == 0, "R8 clear", csr_rdata[3], 0);

        // R7: stop when the request drops
        wr_ctrl(4'h5); idle(); idle();
        frame_end(); idle(); idle(); idle();
        wr_ctrl(4'h1); idle();
        chk(vid_enable == 1, "R7 still on", vid_enable, 1);
        idle();
        chk(vid_enable == 0, "R7 stop", vid_enable, 0);

        // Mixed traffic, checked every cycle against the model
        for (int i = 0; i < 400; i++) begin
            bit [15:0] a;
            case (i % 6)
                0: a = 16'h4000 + 16'(i);
                1: a = 16'h8000 + 16'(i * 3);
                2: a = 16'hC000 + 16'(i);
                default: a = 16'h4000 + 16'(i * 5);
            endcase
            if (i % 53 == 7)       wr_ctrl({1'b0, 1'b0, 1'b0, i[7]});
            else if (i % 41 == 3)  frame_end();
            else if (i % 6 == 5)   drive(1, 1, a, 4'h0, 8'h00);
            else                   rd(a, 8'((i * 13) & 255));
            hf0 = i[3]; hf1 = i[4];
        end
        idle(); idle(); idle(); idle();
        finish_run();
    end
endmodule